// File: doc/BRIEF.md
# Multi-Cycle Prefix-and-Message Byte Packer

The packer assembles one 136-byte output word from an 8-byte prefix and a message whose length, in bytes, is supplied with it. The message bytes keep their positions at the bottom of the word. The prefix is spliced in directly above the last valid message byte, and every byte above the prefix is cleared. A single-cycle version of this splice needs a full-width shifter with 128 possible amounts. This block spends a few cycles instead and applies the prefix displacement one power-of-two step per cycle.

A client drives the prefix, the message and the length, then pulses `start_i` for one cycle while the block is idle. The inputs are captured on that edge. `busy_o` stays high while the shift steps run. When the result is written to `data_o`, `done_o` pulses for one cycle. The result then stays on `data_o` until the next run completes.

Top module: `packer`

## Requirements
- R1: For an effective length L, output bytes 0 to L-1 equal message bytes 0 to L-1. Byte n occupies bits 8n+7:8n on both buses.
- R2: Output bytes L to L+7 hold the prefix, with prefix byte 0 (prefix bits 7:0) at output byte L and prefix byte 7 at output byte L+7.
- R3: Every output byte above L+7 is zero. Message bytes at index L and above never reach the output.
- R4: A `len_i` value of 0, or any value above 128, is treated as L = 128. Values 1 to 128 are used as given.
- R5: A `start_i` sampled high while idle captures the prefix, message and length. Changes on those inputs after that edge do not affect the result of the run.
- R6: `busy_o` is high for exactly 7 cycles, starting the cycle after the start edge. On the 7th edge after the start edge, `done_o` rises for one cycle, `busy_o` falls and `data_o` takes the new result.
- R7: A `start_i` sampled while `busy_o` is high is ignored. The run in progress keeps its timing and its result.
- R8: `data_o` changes only in the cycle in which `done_o` is high. Between runs it holds the last result, whatever the inputs do.
- R9: An active-low asynchronous reset `rst_ni` clears `busy_o`, `done_o` and `data_o` immediately, including in the middle of a run.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | One-cycle request to capture the inputs and begin a run |
| prefix_i | input | 64 | Prefix bytes, byte 0 in bits 7:0 |
| msg_i | input | 1024 | Message bytes, byte 0 in bits 7:0 |
| len_i | input | 8 | Message length in bytes (0 or >128 means 128) |
| busy_o | output | 1 | A run is in progress |
| done_o | output | 1 | One-cycle pulse when a new result is on data_o |
| data_o | output | 1088 | Packed result: message, then prefix, then zeros |

## Verification
The embedded assertions check on every cycle that `done_o` is a single-cycle pulse that follows a busy period and never overlaps with busy. They also check that the step counter stays in range, that the captured shift count is frozen while busy, and that `data_o` changes only in a done cycle. The byte placement across every length from 0 to 130, as well as 255, can only be shown by the bench's scenarios. The same holds for the clamping, the immunity to input changes and repeated starts during a run, and the mid-run reset. The bench compares each result with a value it builds byte by byte from the requirements.

// File: rtl/packer_pkg.sv
package packer_pkg;
  typedef enum logic {ST_IDLE, ST_RUN} packer_state_e;
endpackage

// File: rtl/packer_mask.sv
// Clears message bytes at and above the effective length.
module packer_mask #(
  parameter int BYTE_W    = 8,
  parameter int MSG_BYTES = 128,
  parameter int LEN_W     = 8
) (
  input  logic [MSG_BYTES*BYTE_W-1:0] msg_i,
  input  logic [LEN_W-1:0]            len_i,
  output logic [MSG_BYTES*BYTE_W-1:0] msg_o
);
  for (genvar b = 0; b < MSG_BYTES; b++) begin : g_byte
    localparam logic [LEN_W-1:0] IDX = LEN_W'(b);
    assign msg_o[b*BYTE_W +: BYTE_W] = (IDX < len_i) ? msg_i[b*BYTE_W +: BYTE_W] : '0;
  end
endmodule

// File: rtl/packer_stage.sv
// One power-of-two byte step of the right shift, chosen by the step index.
module packer_stage #(
  parameter int BYTE_W    = 8,
  parameter int OUT_BYTES = 136,
  parameter int SH_W      = 7,
  parameter int STG_W     = 3
) (
  input  logic [OUT_BYTES*BYTE_W-1:0] data_i,
  input  logic [STG_W-1:0]            stage_i,
  input  logic [SH_W-1:0]             k_i,
  output logic [OUT_BYTES*BYTE_W-1:0] data_o
);
  localparam int OUT_W = OUT_BYTES*BYTE_W;

  logic [OUT_W-1:0] cand [SH_W];

  for (genvar s = 0; s < SH_W; s++) begin : g_cand
    assign cand[s] = data_i >> (BYTE_W * (2**s));
  end

  always_comb begin
    data_o = data_i;
    for (int s = 0; s < SH_W; s++) begin
      if (stage_i == STG_W'(s) && k_i[s]) data_o = cand[s];
    end
  end
endmodule

// File: rtl/packer_ctrl.sv
module packer_ctrl
  import packer_pkg::*;
#(
  parameter int SH_W  = 7,
  parameter int STG_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  output logic             capture_o,
  output logic             busy_o,
  output logic             last_o,
  output logic [STG_W-1:0] stage_o,
  output logic             done_o
);
  packer_state_e state_q;
  logic [STG_W-1:0] stage_q;
  logic done_q;

  assign busy_o    = (state_q == ST_RUN);
  assign capture_o = start_i && (state_q == ST_IDLE);
  assign last_o    = busy_o && (stage_q == '0);
  assign stage_o   = stage_q;
  assign done_o    = done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      stage_q <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= last_o;
      if (capture_o) begin
        state_q <= ST_RUN;
        stage_q <= STG_W'(SH_W-1);
      end else if (last_o) begin
        state_q <= ST_IDLE;
      end else if (busy_o) begin
        stage_q <= stage_q - 1'b1;
      end
    end
  end

  assert_done_single_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  assert_done_after_busy_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_o) |-> $past(busy_o));
  assert_no_busy_done_overlap_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(busy_o && done_o));
  assert_stage_range_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> (stage_q < STG_W'(SH_W)));
  assert_start_ignored_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && start_i && !last_o) |=> busy_o);
endmodule

// File: rtl/packer.sv
module packer #(
  parameter int BYTE_W    = 8,
  parameter int PFX_BYTES = 8,
  parameter int MSG_BYTES = 128,
  localparam int LEN_W    = $clog2(MSG_BYTES+1),
  localparam int SH_W     = $clog2(MSG_BYTES),
  localparam int STG_W    = (SH_W > 1) ? $clog2(SH_W) : 1,
  localparam int OUT_BYTES = PFX_BYTES + MSG_BYTES,
  localparam int PFX_W    = PFX_BYTES*BYTE_W,
  localparam int MSG_W    = MSG_BYTES*BYTE_W,
  localparam int OUT_W    = OUT_BYTES*BYTE_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [PFX_W-1:0] prefix_i,
  input  logic [MSG_W-1:0] msg_i,
  input  logic [LEN_W-1:0] len_i,
  output logic             busy_o,
  output logic             done_o,
  output logic [OUT_W-1:0] data_o
);
  localparam logic [LEN_W-1:0] MAX_LEN = LEN_W'(MSG_BYTES);

  logic capture, last;
  logic [STG_W-1:0] stage;
  logic [LEN_W-1:0] len_eff;
  logic [SH_W-1:0]  k_comb, k_q;
  logic [MSG_W-1:0] msg_mask, msg_q;
  logic [OUT_W-1:0] sh_q, sh_next, data_q;

  // out-of-range lengths fall back to a full message
  assign len_eff = (len_i == '0 || len_i > MAX_LEN) ? MAX_LEN : len_i;
  assign k_comb  = SH_W'(MAX_LEN - len_eff);

  packer_ctrl #(.SH_W(SH_W), .STG_W(STG_W)) i_ctrl (
    .clk_i, .rst_ni, .start_i,
    .capture_o(capture), .busy_o, .last_o(last), .stage_o(stage), .done_o
  );

  packer_mask #(.BYTE_W(BYTE_W), .MSG_BYTES(MSG_BYTES), .LEN_W(LEN_W)) i_mask (
    .msg_i, .len_i(len_eff), .msg_o(msg_mask)
  );

  packer_stage #(.BYTE_W(BYTE_W), .OUT_BYTES(OUT_BYTES), .SH_W(SH_W), .STG_W(STG_W)) i_stage (
    .data_i(sh_q), .stage_i(stage), .k_i(k_q), .data_o(sh_next)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      k_q    <= '0;
      msg_q  <= '0;
      sh_q   <= '0;
      data_q <= '0;
    end else begin
      if (capture) begin
        k_q   <= k_comb;
        msg_q <= msg_mask;
        sh_q  <= {prefix_i, {MSG_W{1'b0}}};
      end else if (busy_o) begin
        sh_q <= sh_next;
      end
      if (last) data_q <= sh_next | {{PFX_W{1'b0}}, msg_q};
    end
  end

  assign data_o = data_q;

  assert_data_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> $stable(data_o));
  assert_count_frozen_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |=> $stable(k_q));
endmodule

// File: tb/test_packer.sv
`timescale 1ns/1ps
module test_packer;
  localparam int PB = 8, MB = 128, OB = PB + MB;
  localparam int PW = PB*8, MW = MB*8, OW = OB*8;

  logic clk = 1'b0, rst_ni = 1'b0, start = 1'b0;
  logic [PW-1:0] pfx = '0;
  logic [MW-1:0] msg = '0;
  logic [7:0]    len = '0;
  logic busy, done;
  logic [OW-1:0] data;
  int total = 0, bad = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  packer i_packer (
    .clk_i(clk), .rst_ni, .start_i(start), .prefix_i(pfx), .msg_i(msg),
    .len_i(len), .busy_o(busy), .done_o(done), .data_o(data)
  );

  function automatic logic [OW-1:0] model(logic [PW-1:0] p, logic [MW-1:0] m, int l);
    logic [OW-1:0] r = '0;
    int le = (l == 0 || l > MB) ? MB : l;
    for (int b = 0; b < OB; b++) begin
      if (b < le)           r[b*8 +: 8] = m[b*8 +: 8];
      else if (b < le + PB) r[b*8 +: 8] = p[(b-le)*8 +: 8];
    end
    return r;
  endfunction

  task automatic check_bit(string req, logic act, logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0b exp=%0b", req, act, exp);
    end
  endtask

  task automatic check_data(string req, logic [OW-1:0] exp);
    total++;
    if (data !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, data, exp);
    end
  endtask

  task automatic randomize_inputs();
    for (int w = 0; w < MW/32; w++) msg[w*32 +: 32] = $urandom;
    for (int w = 0; w < PW/32; w++) pfx[w*32 +: 32] = $urandom;
  endtask

  // one run; disturb changes inputs and re-pulses start during the run (R5, R7)
  task automatic run(int l, bit disturb);
    logic [OW-1:0] exp;
    randomize_inputs();
    len = 8'(l);
    exp = model(pfx, msg, l);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check_bit("R6 busy after start", busy, 1'b1);
    if (disturb) begin
      randomize_inputs();
      len = 8'($urandom_range(1, MB));
      start = 1'b1;
    end
    for (int c = 1; c < 7; c++) begin
      @(negedge clk);
      start = 1'b0;
      check_bit("R6/R7 busy mid-run", busy, 1'b1);
      check_bit("R6 done low mid-run", done, 1'b0);
    end
    @(negedge clk);
    check_bit("R6 done pulse", done, 1'b1);
    check_bit("R6 busy falls", busy, 1'b0);
    check_data(disturb ? "R5/R7 R1 R2 R3 R4 result" : "R1 R2 R3 R4 result", exp);
    @(negedge clk);
    check_bit("R6 done one cycle", done, 1'b0);
    check_data("R8 hold after done", exp);
  endtask

  initial begin
    logic [OW-1:0] keep;
    #1;
    check_bit("R9 reset busy", busy, 1'b0);
    check_bit("R9 reset done", done, 1'b0);
    check_data("R9 reset data", '0);
    @(negedge clk);
    @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);

    // sweep all lengths, including clamped ones (R4)
    for (int l = 0; l <= MB + 2; l++) run(l, l % 5 == 3);
    run(255, 1'b0);
    run(1, 1'b1);
    run(MB, 1'b1);

    // R8: inputs change without start
    keep = data;
    randomize_inputs();
    len = 8'd5;
    repeat (4) @(negedge clk);
    check_data("R8 no start no change", keep);
    check_bit("R8 stays idle", busy, 1'b0);

    // R9: reset during a run
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (2) @(negedge clk);
    rst_ni = 1'b0;
    #0.5;
    check_bit("R9 mid-run busy", busy, 1'b0);
    check_bit("R9 mid-run done", done, 1'b0);
    check_data("R9 mid-run data", '0);
    @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    run(40, 1'b0);

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      bad++;
      total++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule